// File: doc/BRIEF.md
# Display Event Interrupt Status Unit

This block sits beside a raster display engine and turns its one-cycle event pulses into one level-sensitive interrupt line for a host processor. Six events are tracked: frame done, sync lost, FIFO underflow, palette load done, and end of frame for buffer 0 and buffer 1. Each pulse sets a sticky bit in a raw status word. An enable mask selects which bits may raise the interrupt. The host sees both the raw word and the masked word.

The host reaches the block through a simple register port. Writes take effect at the clock edge, and reads are combinational from the read address. Enable bits are changed through separate set and clear addresses, so no read-modify-write is needed. Status bits are cleared by writing ones back to them. A write to the end-of-interrupt address drops the interrupt line for one cycle, which gives an edge-triggered interrupt controller a fresh edge when events are still pending.

The register map is:

| Address | Read | Write |
|---|---|---|
| 0 | raw status | write-one-to-clear |
| 1 | masked status | write-one-to-clear |
| 2 | enable mask | set enable bits |
| 3 | enable mask | clear enable bits |
| 4 | zero | end of interrupt |

Top module: `disp_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, raw status, enable mask and masked status all read 0, and `irq_o` is 0.
- R2: A one-cycle event pulse sets its status bit at the next clock edge. The bit positions are: frame done bit 0, sync lost bit 2, FIFO underflow bit 5, palette load done bit 6, end of frame 0 bit 8, end of frame 1 bit 9. All other status bits read 0.
- R3: A write to address 0 (raw status) or address 1 (masked status) clears every status bit written as one. Bits written as zero are unchanged.
- R4: If an event pulse arrives in the same cycle as a write that clears its bit, the bit stays set.
- R5: A write to address 2 sets the enable bits written as one and leaves the others unchanged. Only bits 2, 5, 6, 8 and 9 are implemented; every other enable bit reads 0. Reads at address 2 and at address 3 both return the enable mask.
- R6: A write to address 3 clears the enable bits written as one and leaves the others unchanged.
- R7: Address 1 reads the raw status ANDed with the enable mask.
- R8: `irq_o` is high exactly when the masked status is non-zero, except during the cycle that follows an end-of-interrupt write. Because frame done has no enable bit, it never raises `irq_o`.
- R9: A write to address 4 (end of interrupt) forces `irq_o` low for the one cycle after the write edge. `irq_o` then rises again if masked events are still pending. The write does not change status or the enable mask.
- R10: Sync lost and FIFO underflow accumulate independently, so both can be read set in the same status word.
- R11: Writes to addresses 5 to 7 change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_frame_done_i | input | 1 | Frame done pulse |
| evt_sync_lost_i | input | 1 | Sync lost pulse |
| evt_underflow_i | input | 1 | FIFO underflow pulse |
| evt_pal_done_i | input | 1 | Palette load done pulse |
| evt_eof0_i | input | 1 | End of frame, buffer 0 |
| evt_eof1_i | input | 1 | End of frame, buffer 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit in the status or enable registers shows up on the first read after the edge that stored it. Because the raw and masked views are compared against each other, a mask error separates from a status error at once. A stuck or misplaced end-of-interrupt gap flop shows on `irq_o` in the single cycle after the acknowledge edge. It shows again one cycle later, when the line must come back for events that are still pending. The bench sweeps every enable pattern against every event combination, so a crossed bit position or a missing enable gate appears in the same cycle as a mismatch on one of the three views.

// File: rtl/disp_irq_pkg.sv
// Shared constants for the display event interrupt status unit.
// Assumes the data width is at least 10 bits, so that every event bit fits.
package disp_irq_pkg;
    // Status and enable bit positions
    localparam int BIT_FRAME = 0;
    localparam int BIT_SYNC  = 2;
    localparam int BIT_UNDER = 5;
    localparam int BIT_PAL   = 6;
    localparam int BIT_EOF0  = 8;
    localparam int BIT_EOF1  = 9;

    // Register addresses
    localparam int ADDR_RAW    = 0;
    localparam int ADDR_MASKED = 1;
    localparam int ADDR_ENSET  = 2;
    localparam int ADDR_ENCLR  = 3;
    localparam int ADDR_EOI    = 4;
endpackage

// File: rtl/disp_irq_status.sv
// Sticky status register with write-one-to-clear.
// A set request wins over a clear request on the same bit in the same cycle.
// Bits outside IMPL are held at zero.
module disp_irq_status #(
    parameter int DW = 32,
    parameter logic [DW-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] clr_vec,
    output logic [DW-1:0] status_q
);
    // Update the status: clear the written ones, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= ((status_q & ~clr_vec) | set_vec) & IMPL;
    end

    for (genvar i = 0; i < DW; i++) begin : g_chk
        if (IMPL[i]) begin : g_impl
            assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> status_q[i]);
            assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !set_vec[i]) |=> !status_q[i]);
            assert_collide_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && set_vec[i]) |=> status_q[i]);
        end
    end
endmodule

// File: rtl/disp_irq_enable.sv
// Enable mask with separate set and clear requests.
// Assumes the set and clear requests are never both active (one write address per cycle).
// Bits outside IMPL are held at zero.
module disp_irq_enable #(
    parameter int DW = 32,
    parameter logic [DW-1:0] IMPL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] clr_vec,
    output logic [DW-1:0] en_q
);
    // Apply the set and clear requests to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= ((en_q | set_vec) & ~clr_vec) & IMPL;
    end

    for (genvar i = 0; i < DW; i++) begin : g_chk
        if (IMPL[i]) begin : g_impl
            assert_en_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> en_q[i]);
            assert_en_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
                clr_vec[i] |=> !en_q[i]);
        end
    end
endmodule

// File: rtl/disp_irq_line.sv
// Interrupt line generator.
// The line follows the pending input, and is held low for the one cycle
// that follows an end-of-interrupt request.
module disp_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi_wr,
    output logic irq_o
);
    logic gap_q;

    // Remember an end-of-interrupt request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= 1'b0;
        else        gap_q <= eoi_wr;
    end

    assign irq_o = pending & ~gap_q;

    assert_eoi_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !irq_o);
endmodule

// File: rtl/disp_irq_unit.sv
// Display event interrupt status unit (top level).
// Gathers one-cycle event pulses into raw status, gates them with an enable
// mask, and drives one interrupt line. The register port writes at the clock
// edge and reads combinationally.
// Assumes DW >= 10 and AW >= 3.
module disp_irq_unit
    import disp_irq_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_frame_done_i,
    input  logic          evt_sync_lost_i,
    input  logic          evt_underflow_i,
    input  logic          evt_pal_done_i,
    input  logic          evt_eof0_i,
    input  logic          evt_eof1_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);
    localparam logic [DW-1:0] ONE     = DW'(1);
    localparam logic [DW-1:0] EN_IMPL = (ONE << BIT_SYNC) | (ONE << BIT_UNDER) |
                                        (ONE << BIT_PAL)  | (ONE << BIT_EOF0)  |
                                        (ONE << BIT_EOF1);
    localparam logic [DW-1:0] ST_IMPL = EN_IMPL | (ONE << BIT_FRAME);

    logic [DW-1:0] evt_vec, st_clr, en_set, en_clr, status_q, en_q, masked;
    logic          eoi_wr;

    // Place each event pulse at its status bit position.
    always_comb begin
        evt_vec            = '0;
        evt_vec[BIT_FRAME] = evt_frame_done_i;
        evt_vec[BIT_SYNC]  = evt_sync_lost_i;
        evt_vec[BIT_UNDER] = evt_underflow_i;
        evt_vec[BIT_PAL]   = evt_pal_done_i;
        evt_vec[BIT_EOF0]  = evt_eof0_i;
        evt_vec[BIT_EOF1]  = evt_eof1_i;
    end

    // Decode a register write into set, clear and acknowledge requests.
    always_comb begin
        st_clr = '0;
        en_set = '0;
        en_clr = '0;
        eoi_wr = 1'b0;
        if (wr_en_i) begin
            if (wr_addr_i == AW'(ADDR_RAW) || wr_addr_i == AW'(ADDR_MASKED)) st_clr = wr_data_i;
            if (wr_addr_i == AW'(ADDR_ENSET)) en_set = wr_data_i;
            if (wr_addr_i == AW'(ADDR_ENCLR)) en_clr = wr_data_i;
            if (wr_addr_i == AW'(ADDR_EOI))   eoi_wr = 1'b1;
        end
    end

    disp_irq_status #(.DW(DW), .IMPL(ST_IMPL)) u_status (
        .clk(clk), .rst_n(rst_n), .set_vec(evt_vec), .clr_vec(st_clr), .status_q(status_q));

    disp_irq_enable #(.DW(DW), .IMPL(EN_IMPL)) u_enable (
        .clk(clk), .rst_n(rst_n), .set_vec(en_set), .clr_vec(en_clr), .en_q(en_q));

    assign masked = status_q & en_q;

    disp_irq_line u_line (
        .clk(clk), .rst_n(rst_n), .pending(|masked), .eoi_wr(eoi_wr), .irq_o(irq_o));

    // Select the read data from the read address.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == AW'(ADDR_RAW))    rd_data_o = status_q;
        if (rd_addr_i == AW'(ADDR_MASKED)) rd_data_o = masked;
        if (rd_addr_i == AW'(ADDR_ENSET) || rd_addr_i == AW'(ADDR_ENCLR)) rd_data_o = en_q;
    end

    assert_irq_needs_enabled_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> |(status_q & en_q));
    assert_frame_never_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[BIT_FRAME]);
endmodule

// File: tb/test_disp_irq_unit.sv
module test_disp_irq_unit;
    localparam int AW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          e_frame = 0, e_sync = 0, e_under = 0, e_pal = 0, e_eof0 = 0, e_eof1 = 0;
    logic          wr_en = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    disp_irq_unit #(.AW(AW), .DW(DW)) i_disp_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .evt_frame_done_i(e_frame), .evt_sync_lost_i(e_sync), .evt_underflow_i(e_under),
        .evt_pal_done_i(e_pal), .evt_eof0_i(e_eof0), .evt_eof1_i(e_eof1),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq));

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        rd_addr = AW'(a);
        #1;
        d = rd_data;
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic pulse(input logic [5:0] ev);
        @(negedge clk);
        {e_eof1, e_eof0, e_pal, e_under, e_sync, e_frame} = ev;
        @(negedge clk);
        {e_eof1, e_eof0, e_pal, e_under, e_sync, e_frame} = '0;
    endtask

    function automatic logic [DW-1:0] ev_bits(input logic [5:0] ev);
        logic [DW-1:0] r = '0;
        r[0] = ev[0]; r[2] = ev[1]; r[5] = ev[2]; r[6] = ev[3]; r[8] = ev[4]; r[9] = ev[5];
        return r;
    endfunction

    function automatic logic [DW-1:0] en_bits(input logic [4:0] en);
        logic [DW-1:0] r = '0;
        r[2] = en[0]; r[5] = en[1]; r[6] = en[2]; r[8] = en[3]; r[9] = en[4];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] er, em;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state of every register view and of the interrupt line.
        rd(0, d); chk("R1 raw", d, 0);
        rd(1, d); chk("R1 masked", d, 0);
        rd(2, d); chk("R1 enable", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 R5 R7 R8: sweep every enable pattern against every event set.
        for (int en = 0; en < 32; en++) begin
            for (int ev = 0; ev < 64; ev++) begin
                wr(3, '1);
                wr(0, '1);
                wr(2, '1 & en_bits(5'(en)));
                pulse(6'(ev));
                er = ev_bits(6'(ev));
                em = er & en_bits(5'(en));
                rd(0, d); chk("R2 raw after events", d, er);
                rd(1, d); chk("R7 masked view", d, em);
                chk("R8 irq level", {31'b0, irq}, {31'b0, |em});
            end
        end

        // R5: set with all ones keeps only the implemented bits; both enable addresses read the mask.
        wr(3, '1);
        wr(2, '1);
        rd(2, d); chk("R5 implemented enable bits", d, 32'h364);
        rd(3, d); chk("R5 mask visible at clear address", d, 32'h364);
        // R6: clearing bits 5 and 8 leaves the rest.
        wr(3, 32'h120);
        rd(2, d); chk("R6 partial clear", d, 32'h244);
        // R5: setting bit 5 again leaves the other bits.
        wr(2, 32'h020);
        rd(2, d); chk("R5 partial set", d, 32'h264);

        // R10: sync lost and underflow visible together; R3 partial clear on the raw address.
        wr(0, '1);
        pulse(6'b000010);
        pulse(6'b000100);
        rd(0, d); chk("R10 both recovery bits", d, 32'h024);
        wr(0, 32'h004);
        rd(0, d); chk("R3 raw w1c keeps zero-written bits", d, 32'h020);
        wr(1, 32'h020);
        rd(0, d); chk("R3 w1c via masked address", d, 32'h000);

        // R4: an event coinciding with a clear of its bit stays set.
        @(negedge clk);
        wr_en = 1; wr_addr = 3'd0; wr_data = 32'h020; e_under = 1;
        @(negedge clk);
        wr_en = 0; e_under = 0;
        rd(0, d); chk("R4 collision keeps bit", d, 32'h020);

        // R9: end of interrupt drops irq for one cycle, then it returns.
        chk("R9 irq before ack", {31'b0, irq}, 1);
        @(negedge clk);
        wr_en = 1; wr_addr = 3'd4; wr_data = '0;
        @(negedge clk);
        wr_en = 0;
        chk("R9 irq low after ack", {31'b0, irq}, 0);
        rd(0, d); chk("R9 ack keeps status", d, 32'h020);
        @(negedge clk);
        chk("R9 irq back when pending", {31'b0, irq}, 1);

        // R8: frame done alone never raises irq.
        wr(0, '1);
        wr(2, '1);
        pulse(6'b000001);
        chk("R8 frame done no irq", {31'b0, irq}, 0);

        // R11: unused addresses ignore writes and read zero.
        for (int a = 5; a < 8; a++) begin
            wr(a, '1);
            rd(a, d); chk("R11 unused address reads zero", d, 0);
        end
        rd(0, d); chk("R11 raw unchanged", d, 32'h001);
        rd(2, d); chk("R11 enable unchanged", d, 32'h364);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule